// File: doc/BRIEF.md
# Leveled Interrupt Request Arbiter

This block gathers interrupt requests from many devices, organised as a number of level words of equal width. Each source has a request bit and an enable bit, and a source counts as pending only while both are set. A registered interrupt line tells the processor that at least one source is pending. When the processor acknowledges, the block picks the pending source with the highest priority, drops that request, and one cycle later returns the device number stored for that source in a small writable mapping table.

Devices steer their own interrupt enables through a 2-bit interrupt-control code. The code can enable, disable or disarm the source, and the block returns an armed/disarmed indication for the device to keep. A separate combinational helper applies a generic 2-bit keep/set/clear/complement field to a single bit, for use by device command decoders.

The acknowledge path is a two-state machine. `ST_IDLE` means no reply is being presented. `ST_REPLY` means the device-number reply from the previous cycle's acknowledge is on the outputs. The transition `ST_IDLE -> ST_REPLY` and the transition `ST_REPLY -> ST_REPLY` happen when `ack` is high. The transition `ST_REPLY -> ST_IDLE` and the transition `ST_IDLE -> ST_IDLE` happen when `ack` is low.

Top module: `irq_level_arb`

## Requirements
- R1: A source is pending when both its request and its enable bit are set. `irq` is high in the cycle after any source is pending and low in the cycle after none is.
- R2: The winner is the pending source in the lowest-numbered level word. Within that word, the lowest bit position wins. Source index = level × LVL_W + bit.
- R3: An acknowledge sampled at a clock edge raises `ack_valid` for the next cycle. In that cycle `ack_dev` holds the table entry of the winner, or 0 when nothing was pending.
- R4: An acknowledge clears only the winning request bit. All other requests and all enable bits are kept.
- R5: `ctl_code` 1 sets the enable of `ctl_src` and reports armed (`ctl_armed`=1). Code 2 clears that enable and reports armed. Code 3 clears both the enable and the request of that source and reports disarmed (0). A disabled request is retained and becomes pending again when the source is re-enabled.
- R6: `ctl_code` 0 changes neither enable nor request, and `ctl_armed` echoes `ctl_prev_armed`. `ctl_armed` is combinational and does not depend on `ctl_valid`.
- R7: The field helper gives `fld_new` as follows: op 0 keeps `fld_old`, 1 gives 1, 2 gives 0, 3 gives the complement of `fld_old`.
- R8: `req_set` takes effect at the next edge and wins over any simultaneous clear of the same bit (acknowledge, disarm or `req_clr`). Otherwise `req_clr` clears the bit.
- R9: Writing `tbl_data` to `tbl_addr` with `tbl_we` replaces the device number reported for that source index.
- R10: After reset all requests and enables are clear, `irq`=0, `ack_valid`=0 and `ack_dev`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | NUM_LVL*LVL_W | Per-source request set strobes |
| req_clr | input | NUM_LVL*LVL_W | Per-source request clear strobes |
| ctl_valid | input | 1 | Apply interrupt-control code this cycle |
| ctl_src | input | IDX_W | Source addressed by the control code |
| ctl_code | input | 2 | 0 none, 1 enable, 2 disable, 3 disarm |
| ctl_prev_armed | input | 1 | Device's current armed state |
| ctl_armed | output | 1 | Armed state after the control code |
| fld_op | input | 2 | Generic field op: keep/set/clear/complement |
| fld_old | input | 1 | Bit the field op acts on |
| fld_new | output | 1 | Result of the field op |
| tbl_we | input | 1 | Device-number table write enable |
| tbl_addr | input | IDX_W | Table index (level × LVL_W + bit) |
| tbl_data | input | DEV_W | Device number to store |
| ack | input | 1 | Processor interrupt acknowledge |
| ack_valid | output | 1 | Reply to last cycle's acknowledge |
| ack_dev | output | DEV_W | Device number of acknowledged source, 0 if none |
| irq | output | 1 | Registered any-pending line |

## Verification
The properties assume that inputs are held at zero while reset is asserted, because the request-set check compares against the previous cycle's strobes. They also assume that a control code addresses one source per cycle. The properties that look at `en_q` after a code assume that no other code hits the same source in the following cycle. The stimulus drives every input only between clock edges, keeps all strobes low during reset, issues one control code at a time with a gap cycle after it, and fills the mapping table before any acknowledge that expects a nonzero reply.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        FLD_KEEP = 2'd0,
        FLD_SET  = 2'd1,
        FLD_CLR  = 2'd2,
        FLD_FLIP = 2'd3
    } fld_op_e;

    typedef enum logic [1:0] {
        ICTL_NONE    = 2'd0,
        ICTL_ENABLE  = 2'd1,
        ICTL_DISABLE = 2'd2,
        ICTL_DISARM  = 2'd3
    } ictl_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } ack_state_e;

endpackage

// File: rtl/irq_fld_op.sv
module irq_fld_op
    import irq_arb_pkg::*;
(
    input  logic [1:0] op,
    input  logic       old_bit,
    output logic       new_bit
);
    always_comb begin
        unique case (fld_op_e'(op))
            FLD_KEEP: new_bit = old_bit;
            FLD_SET:  new_bit = 1'b1;
            FLD_CLR:  new_bit = 1'b0;
            FLD_FLIP: new_bit = ~old_bit;
            default:  new_bit = old_bit;
        endcase
    end
endmodule

// File: rtl/irq_ctl_decode.sv
module irq_ctl_decode
    import irq_arb_pkg::*;
(
    input  logic [1:0] code,
    input  logic       prev_armed,
    output logic [1:0] en_op,
    output logic       drop_req,
    output logic       armed
);
    always_comb begin
        en_op    = FLD_KEEP;
        drop_req = 1'b0;
        armed    = prev_armed;
        unique case (ictl_e'(code))
            ICTL_NONE: begin
                en_op = FLD_KEEP;
                armed = prev_armed;
            end
            ICTL_ENABLE: begin
                en_op = FLD_SET;
                armed = 1'b1;
            end
            ICTL_DISABLE: begin
                en_op = FLD_CLR;
                armed = 1'b1;
            end
            ICTL_DISARM: begin
                en_op    = FLD_CLR;
                drop_req = 1'b1;
                armed    = 1'b0;
            end
            default: begin
                en_op = FLD_KEEP;
            end
        endcase
    end
endmodule

// File: rtl/irq_lvl_pick.sv
module irq_lvl_pick #(
    parameter int W = 32,
    localparam int POS_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic             any,
    output logic [POS_W-1:0] pos
);
    always_comb begin
        pos = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) pos = POS_W'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/irq_devmap.sv
module irq_devmap #(
    parameter int ENTRIES = 64,
    parameter int DEV_W   = 8,
    localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [DEV_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DEV_W-1:0] rdata
);
    logic [DEV_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
    import irq_arb_pkg::*;
#(
    parameter int NUM_LVL = 2,
    parameter int LVL_W   = 32,
    parameter int DEV_W   = 8,
    localparam int NUM_SRC = NUM_LVL * LVL_W,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_set,
    input  logic [NUM_SRC-1:0] req_clr,
    input  logic               ctl_valid,
    input  logic [IDX_W-1:0]   ctl_src,
    input  logic [1:0]         ctl_code,
    input  logic               ctl_prev_armed,
    output logic               ctl_armed,
    input  logic [1:0]         fld_op,
    input  logic               fld_old,
    output logic               fld_new,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_addr,
    input  logic [DEV_W-1:0]   tbl_data,
    input  logic               ack,
    output logic               ack_valid,
    output logic [DEV_W-1:0]   ack_dev,
    output logic               irq
);
    localparam int POS_W = (LVL_W > 1) ? $clog2(LVL_W) : 1;

    logic [NUM_SRC-1:0] req_q, req_d, en_q, en_d, pend, req_drop;
    logic [NUM_LVL-1:0] lvl_any;
    logic [POS_W-1:0]   lvl_pos [NUM_LVL];
    logic               win_any;
    logic [IDX_W-1:0]   win_idx;
    logic [DEV_W-1:0]   map_rd, ack_dev_q;
    logic               irq_q;
    logic [1:0]         en_op;
    logic               drop_req, en_old, en_new;
    ack_state_e         state, state_d;

    assign pend = req_q & en_q;

    // per-level lowest-bit pickers
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        irq_lvl_pick #(.W(LVL_W)) pick_i (
            .vec (pend[g*LVL_W +: LVL_W]),
            .any (lvl_any[g]),
            .pos (lvl_pos[g])
        );
    end

    // lowest level with anything pending wins
    always_comb begin
        win_idx = '0;
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            if (lvl_any[l]) win_idx = IDX_W'(l * LVL_W + int'(lvl_pos[l]));
        end
        win_any = |lvl_any;
    end

    irq_devmap #(.ENTRIES(NUM_SRC), .DEV_W(DEV_W)) map_i (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_data),
        .raddr (win_idx),
        .rdata (map_rd)
    );

    irq_ctl_decode dec_i (
        .code       (ctl_code),
        .prev_armed (ctl_prev_armed),
        .en_op      (en_op),
        .drop_req   (drop_req),
        .armed      (ctl_armed)
    );

    assign en_old = en_q[ctl_src];

    irq_fld_op en_fld_i (
        .op      (en_op),
        .old_bit (en_old),
        .new_bit (en_new)
    );

    irq_fld_op gen_fld_i (
        .op      (fld_op),
        .old_bit (fld_old),
        .new_bit (fld_new)
    );

    // next request / enable vectors
    always_comb begin
        en_d     = en_q;
        req_drop = '0;
        if (ctl_valid) begin
            en_d[ctl_src] = en_new;
            if (drop_req) req_drop[ctl_src] = 1'b1;
        end
        if (ack && win_any) req_drop[win_idx] = 1'b1;
        req_d = req_set | (req_q & ~req_clr & ~req_drop);
    end

    // acknowledge state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  state_d = ack ? ST_REPLY : ST_IDLE;
            ST_REPLY: state_d = ack ? ST_REPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs from state
    always_comb begin
        unique case (state)
            ST_IDLE:  ack_valid = 1'b0;
            ST_REPLY: ack_valid = 1'b1;
            default:  ack_valid = 1'b0;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q     <= '0;
            en_q      <= '0;
            irq_q     <= 1'b0;
            ack_dev_q <= '0;
        end else begin
            req_q     <= req_d;
            en_q      <= en_d;
            irq_q     <= win_any;
            ack_dev_q <= (ack && win_any) ? map_rd : '0;
        end
    end

    assign ack_dev = ack_dev_q;
    assign irq     = irq_q;
endmodule

// File: rtl/irq_level_arb_chk.sv
module irq_level_arb_chk #(
    parameter int NUM_SRC = 64,
    parameter int IDX_W   = 6,
    parameter int DEV_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] req_set,
    input logic [NUM_SRC-1:0] req_q,
    input logic [NUM_SRC-1:0] en_q,
    input logic               ctl_valid,
    input logic [IDX_W-1:0]   ctl_src,
    input logic [1:0]         ctl_code,
    input logic               ctl_armed,
    input logic [1:0]         fld_op,
    input logic               fld_old,
    input logic               fld_new,
    input logic               ack,
    input logic               ack_valid,
    input logic [DEV_W-1:0]   ack_dev,
    input logic               irq
);
    p_irq_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_q & en_q) == '0) |=> !irq);

    p_irq_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_q & en_q) != '0) |=> irq);

    p_reply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ack_valid);

    p_no_reply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> (!ack_valid && ack_dev == '0));

    p_empty_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (req_q & en_q) == '0) |=> ack_dev == '0);

    p_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_code == 2'd1) |=> en_q[$past(ctl_src)]);

    p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_code == 2'd3) |-> !ctl_armed);

    p_disarm_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_code == 2'd3) |=> !en_q[$past(ctl_src)]);

    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_code == 2'd0) |=> en_q[$past(ctl_src)] == $past(en_q[ctl_src]));

    p_fld_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_op == 2'd0) |-> fld_new == fld_old);

    p_fld_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_op == 2'd3) |-> fld_new != fld_old);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (req_q & $past(req_set)) == $past(req_set));
endmodule

bind irq_level_arb irq_level_arb_chk #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W),
    .DEV_W   (DEV_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_set   (req_set),
    .req_q     (req_q),
    .en_q      (en_q),
    .ctl_valid (ctl_valid),
    .ctl_src   (ctl_src),
    .ctl_code  (ctl_code),
    .ctl_armed (ctl_armed),
    .fld_op    (fld_op),
    .fld_old   (fld_old),
    .fld_new   (fld_new),
    .ack       (ack),
    .ack_valid (ack_valid),
    .ack_dev   (ack_dev),
    .irq       (irq)
);

// File: tb/irq_level_arb_tb_top.sv
module irq_level_arb_tb_top;
    localparam int NSRC = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] req_set = '0, req_clr = '0;
    logic            ctl_valid = 1'b0;
    logic [5:0]      ctl_src = '0;
    logic [1:0]      ctl_code = '0;
    logic            ctl_prev_armed = 1'b0;
    logic            ctl_armed;
    logic [1:0]      fld_op = '0;
    logic            fld_old = 1'b0;
    logic            fld_new;
    logic            tbl_we = 1'b0;
    logic [5:0]      tbl_addr = '0;
    logic [7:0]      tbl_data = '0;
    logic            ack = 1'b0;
    logic            ack_valid;
    logic [7:0]      ack_dev;
    logic            irq;

    int  nchk = 0;
    int  nfail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    irq_level_arb dut_i (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_clr(req_clr),
        .ctl_valid(ctl_valid), .ctl_src(ctl_src), .ctl_code(ctl_code),
        .ctl_prev_armed(ctl_prev_armed), .ctl_armed(ctl_armed),
        .fld_op(fld_op), .fld_old(fld_old), .fld_new(fld_new),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .ack(ack), .ack_valid(ack_valid), .ack_dev(ack_dev), .irq(irq)
    );

    // {ctl_code, prev, exp_armed, fld_op, fld_old, exp_new}
    localparam logic [7:0] VEC [8] = '{
        8'b00_0_0_00_0_0,
        8'b00_1_1_00_1_1,
        8'b01_0_1_01_0_1,
        8'b01_1_1_01_1_1,
        8'b10_0_1_10_1_0,
        8'b10_1_1_10_0_0,
        8'b11_1_0_11_0_1,
        8'b11_0_0_11_1_0
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_req(input int i);
        req_set[i] = 1'b1;
        step();
        req_set = '0;
    endtask

    task automatic ctl(input int i, input logic [1:0] code, input logic prev,
                       input logic exp_armed, input string tag);
        ctl_valid = 1'b1;
        ctl_src = 6'(i);
        ctl_code = code;
        ctl_prev_armed = prev;
        #1;
        chk(tag, ctl_armed, exp_armed);
        step();
        ctl_valid = 1'b0;
        ctl_code = 2'd0;
        step();
    endtask

    task automatic do_ack(input logic [7:0] exp_dev, input string tag);
        ack = 1'b1;
        step();
        ack = 1'b0;
        chk({tag, " valid"}, ack_valid, 1'b1);
        chk({tag, " dev"}, ack_dev, exp_dev);
    endtask

    initial begin
        #400000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R10 reset state
        chk("R10 irq", irq, 1'b0);
        chk("R10 ack_valid", ack_valid, 1'b0);
        chk("R10 ack_dev", ack_dev, 8'h00);

        // R6 R7 combinational vector walk
        for (int v = 0; v < 8; v++) begin
            ctl_code = VEC[v][7:6];
            ctl_prev_armed = VEC[v][5];
            fld_op = VEC[v][3:2];
            fld_old = VEC[v][1];
            #1;
            chk("R6/R5 armed", ctl_armed, VEC[v][4]);
            chk("R7 field", fld_new, VEC[v][0]);
        end
        ctl_code = 2'd0;
        fld_op = 2'd0;

        // R9 fill table
        for (int i = 0; i < NSRC; i++) begin
            tbl_we = 1'b1;
            tbl_addr = 6'(i);
            tbl_data = 8'(8'h40 + i);
            step();
        end
        tbl_we = 1'b0;

        // R1: request without enable is not pending
        set_req(5);
        step();
        chk("R1 masked", irq, 1'b0);
        do_ack(8'h00, "R3 empty");

        ctl(5, 2'd1, 1'b0, 1'b1, "R5 enable armed");
        step();
        chk("R1 pending", irq, 1'b1);
        ctl(5, 2'd0, 1'b1, 1'b1, "R6 none armed");
        chk("R6 kept enable", irq, 1'b1);

        // R2 priority
        ctl(30, 2'd1, 1'b0, 1'b1, "R5 enable 30");
        ctl(32, 2'd1, 1'b0, 1'b1, "R5 enable 32");
        req_set[30] = 1'b1;
        req_set[32] = 1'b1;
        step();
        req_set = '0;
        do_ack(8'h45, "R2 lowest bit");
        do_ack(8'h5E, "R2 lower level");
        do_ack(8'h60, "R4 others kept");
        do_ack(8'h00, "R4 drained");
        step();
        chk("R4 irq drained", irq, 1'b0);

        // R5 disable / disarm
        ctl(7, 2'd1, 1'b0, 1'b1, "R5 enable 7");
        set_req(7);
        step();
        chk("R5 on", irq, 1'b1);
        ctl(7, 2'd2, 1'b1, 1'b1, "R5 disable armed");
        chk("R5 disabled", irq, 1'b0);
        ctl(7, 2'd1, 1'b1, 1'b1, "R5 reenable");
        chk("R5 request retained", irq, 1'b1);
        ctl(7, 2'd3, 1'b1, 1'b0, "R5 disarm");
        chk("R5 disarmed off", irq, 1'b0);
        ctl(7, 2'd1, 1'b0, 1'b1, "R5 enable after disarm");
        chk("R5 request dropped", irq, 1'b0);

        // R8 set wins over acknowledge clear
        ctl(9, 2'd1, 1'b0, 1'b1, "R8 enable 9");
        set_req(9);
        ack = 1'b1;
        req_set[9] = 1'b1;
        step();
        ack = 1'b0;
        req_set = '0;
        chk("R8 first dev", ack_dev, 8'h49);
        do_ack(8'h49, "R8 set survived");
        do_ack(8'h00, "R8 drained");

        // R8 clear strobe
        ctl(12, 2'd1, 1'b0, 1'b1, "R8 enable 12");
        set_req(12);
        req_clr[12] = 1'b1;
        step();
        req_clr = '0;
        step();
        chk("R8 cleared", irq, 1'b0);

        // R9 rewrite entry, R2 top index
        tbl_we = 1'b1;
        tbl_addr = 6'd12;
        tbl_data = 8'hA5;
        step();
        tbl_we = 1'b0;
        set_req(12);
        do_ack(8'hA5, "R9 rewritten");
        ctl(63, 2'd1, 1'b0, 1'b1, "R2 enable 63");
        set_req(63);
        do_ack(8'h7F, "R2 top index");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule